// File: doc/BRIEF.md
# Two-Digit Radix-4 Synchronous Counter

This block counts from 0 to 15 using two radix-4 digits, each held on 2 bits. Every digit is kept in a storage cell whose next value is the larger of its A input and the smaller of its B input and its current value. The cell never needs the complement of its own state. To hold, a cell gets A at the lowest level and B at the top level. To load a new value, it gets B at the lowest level and the new value on A.

The low digit takes one cyclic step on every enabled clock. The high digit takes one cyclic step on the same edge, but only when the low digit sits at the top level. A threshold comparison detects that condition, not an exact-match test. Both digits share one clock, so the count moves as a single value. A flag shows when both digits are at the top level, which is the last count before the wrap.

Top module: `quat_counter2`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both digits become 0 after that edge.
- R2: When `cnt_en` is high and reset is inactive, `digit_lo` steps 0→1→2→3→0 on every rising edge.
- R3: `digit_hi` steps by one, modulo 4, on an enabled edge where `digit_lo` equals 3 before the edge. On any other edge with reset inactive it keeps its value.
- R4: When `cnt_en` is low and reset is inactive, both digits keep their values across the edge.
- R5: `at_max` is 1 exactly when `digit_lo` equals 3 and `digit_hi` equals 3, and is 0 otherwise.
- R6: An enabled edge while the count is 15 (both digits 3) returns both digits to 0.
- R7: Reset wins over `cnt_en`. With both low reset and high enable at an edge, the digits become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable, active high |
| digit_lo | output | 2 | Least significant radix-4 digit (0..3) |
| digit_hi | output | 2 | Most significant radix-4 digit (0..3) |
| at_max | output | 1 | High while the count equals 15 |

## Verification
The properties assume `rst_n` is low on the first clock edges, so no comparison with a past value is made before the digits hold known values. They also assume `cnt_en` and `rst_n` stay stable around the rising edge. The stimulus changes both inputs only on the falling edge, and it starts with reset asserted. Enable runs are long enough to cross every low-digit carry and the 15-to-0 wrap. Enable is also toggled in a pattern that leaves the count sitting on carry positions while holding.

// File: rtl/qc_pkg.sv
package qc_pkg;
   // Allowed ways to recognise the top level of a digit for carry purposes
   typedef enum logic [0:0] {
      CARRY_THRESHOLD = 1'b0,
      CARRY_EXACT     = 1'b1
   } carry_det_e;
endpackage

// File: rtl/qc_ab_cell.sv
// Storage element: next = MAX(a, MIN(b, q)); no inverted state anywhere.
module qc_ab_cell #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] q
);
   logic [W-1:0] kept;
   logic [W-1:0] nxt;

   always_comb begin
      kept = (b < q) ? b : q;
      nxt  = (a > kept) ? a : kept;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/qc_carry_det.sv
// Produces the top level when the digit is at its top value, else level 0.
module qc_carry_det #(
   parameter int              RADIX = 4,
   parameter int              W     = 2,
   parameter qc_pkg::carry_det_e MODE = qc_pkg::CARRY_THRESHOLD
) (
   input  logic [W-1:0] q,
   output logic [W-1:0] lvl
);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   generate
      if (MODE == qc_pkg::CARRY_THRESHOLD) begin : g_thresh
         // upper threshold: no equality literal needed
         assign lvl = (q >= TOP) ? TOP : '0;
      end else begin : g_exact
         assign lvl = (q == TOP) ? TOP : '0;
      end
   endgenerate
endmodule

// File: rtl/qc_excite.sv
// Builds A/B drives for one digit from its value and its incoming carry level.
module qc_excite #(
   parameter int RADIX = 4,
   parameter int W     = 2
) (
   input  logic [W-1:0] q,
   input  logic [W-1:0] gate,
   output logic [W-1:0] a,
   output logic [W-1:0] b
);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   logic [W-1:0] step;

   always_comb begin
      // one-position clockwise cycle
      step = (q >= TOP) ? '0 : q + 1'b1;
      // MIN with the gate: full step when gate is TOP, level 0 otherwise
      a    = (gate < step) ? gate : step;
      // lower threshold on the gate: keep path open only when not advancing
      b    = (gate < TOP) ? TOP : '0;
   end
endmodule

// File: rtl/quat_counter2.sv
module quat_counter2 #(
   parameter int                 RADIX    = 4,
   parameter qc_pkg::carry_det_e CARRY_MD = qc_pkg::CARRY_THRESHOLD
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cnt_en,
   output logic [$clog2(RADIX)-1:0]   digit_lo,
   output logic [$clog2(RADIX)-1:0]   digit_hi,
   output logic                       at_max
);
   localparam int           W     = $clog2(RADIX);
   localparam int           NDIG  = 2;
   localparam logic [W-1:0] TOP   = W'(RADIX - 1);

   generate
      if (RADIX < 2) begin : g_bad_radix
         $error("quat_counter2: RADIX must be at least 2");
      end
   endgenerate

   logic [W-1:0] dig   [NDIG];
   logic [W-1:0] cdet  [NDIG];
   logic [W-1:0] gate  [NDIG+1];

   assign gate[0] = cnt_en ? TOP : '0;

   generate
      for (genvar i = 0; i < NDIG; i++) begin : g_digit
         logic [W-1:0] drv_a;
         logic [W-1:0] drv_b;

         qc_excite #(.RADIX(RADIX), .W(W)) u_exc (
            .q    (dig[i]),
            .gate (gate[i]),
            .a    (drv_a),
            .b    (drv_b)
         );

         qc_ab_cell #(.W(W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .a     (drv_a),
            .b     (drv_b),
            .q     (dig[i])
         );

         qc_carry_det #(.RADIX(RADIX), .W(W), .MODE(CARRY_MD)) u_det (
            .q   (dig[i]),
            .lvl (cdet[i])
         );

         // carry chain: multilevel AND (MIN) of enable and lower-digit carries
         assign gate[i+1] = (cdet[i] < gate[i]) ? cdet[i] : gate[i];
      end
   endgenerate

   assign digit_lo = dig[0];
   assign digit_hi = dig[1];

   logic [W-1:0] all_top;
   assign all_top = (cdet[0] < cdet[1]) ? cdet[0] : cdet[1];
   assign at_max  = (all_top == TOP);
endmodule

// File: rtl/qc_counter_chk.sv
module qc_counter_chk #(
   parameter int RADIX = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cnt_en,
   input logic [$clog2(RADIX)-1:0] digit_lo,
   input logic [$clog2(RADIX)-1:0] digit_hi,
   input logic                     at_max
);
   localparam int           W   = $clog2(RADIX);
   localparam logic [W-1:0] TOP = W'(RADIX - 1);

   function automatic logic [W-1:0] nxt(input logic [W-1:0] v);
      return (v == TOP) ? '0 : v + 1'b1;
   endfunction

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (digit_lo == '0 && digit_hi == '0));

   assert_lo_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> digit_lo == nxt($past(digit_lo)));

   assert_hi_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && digit_lo == TOP) |=> digit_hi == nxt($past(digit_hi)));

   assert_hi_stay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_en && digit_lo == TOP) |=> $stable(digit_hi));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> ($stable(digit_lo) && $stable(digit_hi)));

   assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      at_max == (digit_lo == TOP && digit_hi == TOP));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && at_max) |=> (digit_lo == '0 && digit_hi == '0));
endmodule

bind quat_counter2 qc_counter_chk #(.RADIX(RADIX)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_en   (cnt_en),
   .digit_lo (digit_lo),
   .digit_hi (digit_hi),
   .at_max   (at_max)
);

// File: tb/quat_counter2_test.sv
module quat_counter2_test;
   typedef struct {
      int    val;
      bit    flag;
      string req;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_en = 1'b0;
   logic [1:0] digit_lo;
   logic [1:0] digit_hi;
   logic       at_max;

   int   checks = 0;
   int   failures = 0;
   int   model = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz

   quat_counter2 uut (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .digit_lo(digit_lo), .digit_hi(digit_hi), .at_max(at_max)
   );

   // driver: apply inputs on falling edge, queue the value expected after next rise
   task automatic drive(input bit rst, input bit en);
      exp_t e;
      @(negedge clk);
      rst_n  = ~rst;
      cnt_en = en;
      if (rst)            e.req = en ? "R7" : "R1";
      else if (!en)       e.req = "R4";
      else if (model == 15) e.req = "R6";
      else if (model % 4 == 3) e.req = "R3";
      else                e.req = "R2";
      if (rst)      model = 0;
      else if (en)  model = (model + 1) % 16;
      e.val  = model;
      e.flag = (model == 15);
      sb.push_back(e);
   endtask

   // monitor: sample mid-cycle after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            int   got;
            e   = sb.pop_front();
            got = digit_hi * 4 + digit_lo;
            checks++;
            if (got !== e.val) begin
               failures++;
               $display("FAIL %s count actual=%0d expected=%0d", e.req, got, e.val);
            end
            checks++;
            if (at_max !== e.flag) begin
               failures++;
               $display("FAIL R5 at_max actual=%0b expected=%0b (count %0d)", at_max, e.flag, e.val);
            end
         end
      end
   end

   initial begin
      drive(1, 0);
      drive(1, 0);                                  // R1 reset state
      for (int i = 0; i < 20; i++) drive(0, 1);     // R2, R3, R6 wrap, R5 flag
      for (int i = 0; i < 3; i++) drive(0, 0);      // R4 hold
      for (int i = 0; i < 12; i++) drive(0, (i % 3) != 0); // R4 mixed
      drive(1, 1);                                  // R7 reset beats enable
      for (int i = 0; i < 15; i++) drive(0, 1);     // reach 15
      drive(0, 0);                                  // R4 hold at 15, R5
      drive(0, 0);
      drive(0, 1);                                  // R6 wrap
      for (int i = 0; i < 7; i++) drive(0, 1);
      drive(1, 0);                                  // R1 mid-count reset
      drive(0, 1);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         failures++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule